// File: doc/BRIEF.md
# Infrared Beam Curtain Sequencer

This block drives a vertical curtain of infrared emitter and receiver pairs that reads the side silhouette of a passing vehicle, one column at a time. While a vehicle-presence input is high, the block starts a scan frame at a fixed interval. Each frame begins with a burst of a square-wave carrier that is sent to every emitter at once. Near the end of the burst, while the emitters are still lit, the block copies the receiver array into a column register. In that register a 1 marks a blocked beam and a 0 marks a clear path.

A fixed settling delay after the burst, three enable strobes fire together to tell the height, length and axle units that a new column is ready. When presence drops, the frame in progress runs to completion and the block then issues a single classify strobe. No further bursts start until presence rises again.

The column output is not a stream. It carries no valid/ready pair and takes no back-pressure. The enable strobes qualify it, and it holds its value until the next sample point, so consumers have most of a frame to read it. The presence input passes through a two-stage synchroniser before any decision is made. The receiver inputs are registered only at the sample point.

Top module: `beam_sequencer`

## Requirements
- R1: During a burst, every emitter output carries a square wave that starts high. The wave is high for HALF_CYC clocks and then low for HALF_CYC clocks. It repeats for BURST_PERIODS periods, so the burst lasts BL = 2·HALF_CYC·BURST_PERIODS clocks.
- R2: All N_BEAMS emitter outputs are identical in every cycle, and they are all 0 outside a burst.
- R3: A burst starts 3 clocks after presence_in rises: two synchroniser stages plus the controller register. While presence stays high, burst starts are exactly FRAME_CYC clocks apart. No burst starts while presence is low.
- R4: Bit i of column_out takes rx_in[i], where 1 means blocked and 0 means clear. It does so at the clock edge that ends the last high clock of the final carrier period, which is burst cycle BL-HALF_CYC-1. At all other times column_out holds, and changes on rx_in have no effect on it.
- R5: en_height, en_length and en_axle pulse together for one clock, at burst cycle BL+SETTLE_CYC. At that moment the emitters are dark and column_out is steady.
- R6: classify pulses for exactly one clock per vehicle. If presence falls after the enable strobe, classify appears 3 clocks after the fall. If presence falls during the burst or the settling delay, the frame completes and classify appears 2 clocks after the enable strobe.
- R7: Under reset (rst_n low) all outputs are 0, column_out included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presence_in | input | 1 | Vehicle-presence level, asynchronous |
| rx_in | input | N_BEAMS | Receiver array; 1 = beam blocked |
| emit_out | output | N_BEAMS | Carrier drive to every emitter |
| column_out | output | N_BEAMS | Latched profile column |
| en_height | output | 1 | Column-ready strobe for the height unit |
| en_length | output | 1 | Column-ready strobe for the length unit |
| en_axle | output | 1 | Column-ready strobe for the axle unit |
| classify | output | 1 | One-clock end-of-vehicle strobe |

## Verification
If the frame counter were wrong, burst starts would drift off the FRAME_CYC grid, and this would show on emit_out at the second burst of a vehicle. If the burst counter were off by one, the carrier would gain or lose a half-period, or the sample would land a clock early or late. Driving the receivers to the complement one clock after the sample point would then expose this at the next enable strobe. If the state sequence were wrong, the strobe or classify would move away from its fixed offset from the burst start, or would pulse twice, and the error would appear within one frame of the fault.

// File: rtl/beam_seq_pkg.sv
package beam_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BURST,
    ST_SETTLE,
    ST_STROBE,
    ST_WAIT,
    ST_CLASSIFY
  } seq_state_t;
endpackage

// File: rtl/beam_presence_sync.sv
module beam_presence_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/beam_carrier.sv
module beam_carrier #(
  parameter int HALF_CYC = 658
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic lit
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);

  logic [HW-1:0] half_cnt;
  logic          phase_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      phase_hi <= 1'b1;
    end else if (!run) begin
      half_cnt <= '0;
      phase_hi <= 1'b1;
    end else if (half_cnt == HALF_LAST) begin
      half_cnt <= '0;
      phase_hi <= ~phase_hi;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  assign lit = run & phase_hi;

  // R1: every burst opens with the high half of the carrier
  a_r1_burst_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> lit);
endmodule

// File: rtl/beam_seq_ctrl.sv
module beam_seq_ctrl
  import beam_seq_pkg::*;
#(
  parameter int HALF_CYC      = 658,
  parameter int BURST_PERIODS = 38,
  parameter int SETTLE_CYC    = 16,
  parameter int FRAME_CYC     = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pres_s,
  input  logic lit,
  output logic run,
  output logic sample,
  output logic strobe,
  output logic classify
);
  localparam int BURST_CYC = 2 * HALF_CYC * BURST_PERIODS;
  localparam int SAMPLE_AT = BURST_CYC - HALF_CYC - 1;
  localparam int BW = $clog2(BURST_CYC);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int FW = $clog2(FRAME_CYC);
  localparam logic [BW-1:0] B_LAST   = BW'(BURST_CYC - 1);
  localparam logic [BW-1:0] B_SAMPLE = BW'(SAMPLE_AT);
  localparam logic [SW-1:0] S_LAST   = SW'(SETTLE_CYC - 1);
  localparam logic [FW-1:0] F_LAST   = FW'(FRAME_CYC - 1);

  seq_state_t    state;
  logic [BW-1:0] burst_cnt;
  logic [SW-1:0] settle_cnt;
  logic [FW-1:0] frame_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      burst_cnt  <= '0;
      settle_cnt <= '0;
      frame_cnt  <= '0;
    end else begin
      if (state != ST_IDLE) frame_cnt <= frame_cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          frame_cnt <= '0;
          burst_cnt <= '0;
          if (pres_s) state <= ST_BURST;
        end
        ST_BURST: begin
          burst_cnt <= burst_cnt + 1'b1;
          if (burst_cnt == B_LAST) begin
            settle_cnt <= '0;
            state      <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          settle_cnt <= settle_cnt + 1'b1;
          if (settle_cnt == S_LAST) state <= ST_STROBE;
        end
        ST_STROBE: state <= ST_WAIT;
        ST_WAIT: begin
          if (!pres_s) begin
            state <= ST_CLASSIFY;
          end else if (frame_cnt == F_LAST) begin
            state     <= ST_BURST;
            burst_cnt <= '0;
            frame_cnt <= '0;
          end
        end
        ST_CLASSIFY: state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assign run      = (state == ST_BURST);
  assign sample   = run && (burst_cnt == B_SAMPLE);
  assign strobe   = (state == ST_STROBE);
  assign classify = (state == ST_CLASSIFY);

  // R4: the receiver sample lands while the carrier is in its high half
  a_r4_sample_while_lit: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> lit);
  // R3: a burst only starts after the synchronised presence was seen high
  a_r3_start_needs_presence: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(pres_s));
  // R6: classify lasts a single clock
  a_r6_classify_single: assert property (@(posedge clk) disable iff (!rst_n)
    classify |=> !classify);
  // R6: classify follows a low synchronised presence
  a_r6_classify_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    classify |-> !$past(pres_s));
endmodule

// File: rtl/beam_sequencer.sv
module beam_sequencer #(
  parameter int N_BEAMS       = 10,
  parameter int HALF_CYC      = 658,
  parameter int BURST_PERIODS = 38,
  parameter int SETTLE_CYC    = 16,
  parameter int FRAME_CYC     = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               presence_in,
  input  logic [N_BEAMS-1:0] rx_in,
  output logic [N_BEAMS-1:0] emit_out,
  output logic [N_BEAMS-1:0] column_out,
  output logic               en_height,
  output logic               en_length,
  output logic               en_axle,
  output logic               classify
);
  logic pres_s, lit, run, sample, strobe;

  beam_presence_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(presence_in), .sync_out(pres_s)
  );

  beam_carrier #(.HALF_CYC(HALF_CYC)) u_carrier (
    .clk(clk), .rst_n(rst_n), .run(run), .lit(lit)
  );

  beam_seq_ctrl #(
    .HALF_CYC(HALF_CYC), .BURST_PERIODS(BURST_PERIODS),
    .SETTLE_CYC(SETTLE_CYC), .FRAME_CYC(FRAME_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pres_s(pres_s), .lit(lit),
    .run(run), .sample(sample), .strobe(strobe), .classify(classify)
  );

  for (genvar i = 0; i < N_BEAMS; i++) begin : g_emit
    assign emit_out[i] = lit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      column_out <= '0;
    else if (sample) column_out <= rx_in;
  end

  assign en_height = strobe;
  assign en_length = strobe;
  assign en_axle   = strobe;

  // R5: the strobe sees dark emitters and a column that is not moving
  a_r5_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    en_height |-> (emit_out == '0) && $stable(column_out));
  // R4: column only changes while a burst is running
  a_r4_column_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(column_out) |-> $past(run));
endmodule

// File: tb/tb_beam_sequencer.sv
module tb_beam_sequencer;
  localparam int N      = 10;
  localparam int HALF   = 3;
  localparam int NPER   = 4;
  localparam int SETTLE = 5;
  localparam int FRAME  = 80;
  localparam int BL     = 2 * HALF * NPER;
  localparam int SAMP   = BL - HALF - 1;
  localparam logic [N-1:0] ALL1 = '1;

  logic clk = 0, rst_n = 0, presence_in = 0;
  logic [N-1:0] rx_in = '0;
  logic [N-1:0] emit_out, column_out;
  logic en_height, en_length, en_axle, classify;

  beam_sequencer #(
    .N_BEAMS(N), .HALF_CYC(HALF), .BURST_PERIODS(NPER),
    .SETTLE_CYC(SETTLE), .FRAME_CYC(FRAME)
  ) dut (.*);

  always #10 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int b = -1, last_b = -1, rise_cyc = -1, nbursts = 0, exp_cls = -1, n_cls = 0;
  bit armed = 0, done = 0;
  logic [N-1:0] exp_q[$];
  logic [N-1:0] last_p;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    int k;
    logic [N-1:0] expw, got;
    if (armed) begin
      if (emit_out != '0 && (b < 0 || cyc - b >= BL)) begin
        if (last_b >= 0) chk(cyc - last_b == FRAME, "R3", "burst spacing", cyc - last_b, FRAME);
        else chk(cyc - rise_cyc == 3, "R3", "start latency", cyc - rise_cyc, 3);
        last_b = cyc; b = cyc; nbursts++;
      end
      if (b >= 0) begin
        k = cyc - b;
        expw = (k < BL && ((k / HALF) % 2 == 0)) ? ALL1 : '0;
        chk(emit_out == expw, (k < BL) ? "R1" : "R2", "emitter level", int'(emit_out), int'(expw));
      end else begin
        k = 0;
        chk(emit_out == '0, "R2", "dark before first burst", int'(emit_out), 0);
      end
      if (en_height | en_length | en_axle) begin
        chk(en_height & en_length & en_axle, "R5", "strobes together",
            int'({en_height, en_length, en_axle}), 7);
        chk(k == BL + SETTLE, "R5", "strobe offset", k, BL + SETTLE);
        if (exp_q.size() == 0) chk(0, "R4", "unexpected column", int'(column_out), -1);
        else begin
          got = exp_q.pop_front();
          chk(column_out == got, "R4", "column at strobe", int'(column_out), int'(got));
        end
      end
      if (classify) begin
        n_cls++;
        chk(cyc == exp_cls, "R6", "classify cycle", cyc, exp_cls);
        last_b = -1;
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic vehicle(int nframes, bit mid_fall, logic [N-1:0] seed);
    step();
    presence_in = 1; rise_cyc = cyc;
    for (int f = 0; f < nframes; f++) begin
      int nb0;
      logic [N-1:0] p;
      nb0 = nbursts;
      while (nbursts == nb0) step();
      p = seed ^ N'(f * 37 + 5);
      while (cyc - b < 46) begin
        int k;
        k = cyc - b;
        if (k == SAMP) begin rx_in = p; exp_q.push_back(p); last_p = p; end
        else if (k == SAMP + 1) rx_in = ~p;
        else if (k < SAMP) rx_in = ~p ^ N'(k);
        if (f == nframes - 1) begin
          if (mid_fall && k == 10) begin presence_in = 0; exp_cls = b + BL + SETTLE + 2; end
          if (!mid_fall && k == 40) begin presence_in = 0; exp_cls = cyc + 3; end
        end
        step();
      end
    end
    // idle with receiver noise: no burst, column held (R3, R4)
    for (int i = 0; i < 60; i++) begin
      rx_in = rx_in + N'(7);
      step();
    end
    chk(column_out == last_p, "R4", "column held while idle", int'(column_out), int'(last_p));
  endtask

  initial begin
    repeat (3) step();
    // R7: reset state
    chk(emit_out == '0 && column_out == '0, "R7", "data outputs in reset",
        int'(emit_out | column_out), 0);
    chk({en_height, en_length, en_axle, classify} == 4'b0, "R7", "strobes in reset",
        int'({en_height, en_length, en_axle, classify}), 0);
    rst_n = 1;
    armed = 1;
    repeat (10) step();
    vehicle(3, 0, 10'h2A5);
    vehicle(1, 1, 10'h0F3);
    vehicle(2, 1, 10'h3C1);
    chk(n_cls == 3, "R6", "classify count", n_cls, 3);
    chk(exp_q.size() == 0, "R5", "columns left unstrobed", exp_q.size(), 0);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R3", "watchdog expired", cyc, 0);
    finish_up();
  end
endmodule